// File: doc/BRIEF.md
# Device Time Counter with Pulse-Aligned Load

This block keeps a free-running device time value that advances by one tick on every master clock cycle, where one tick is one clock period (10 ns at a 100 MHz clock). A host command port can overwrite the value at once or arm a value to be taken on the next rising edge of an external once-per-second pulse. The host can also capture a snapshot of the current value.

A scheduling port accepts one timestamped transmit request at a time. It holds the request until device time equals the absolute timestamp and then releases it in that exact cycle. A request whose time has already passed is released at once and flagged as late. The pulse input is asynchronous and passes through a synchronizer before it is used.

Top module: `tod_counter`

## Requirements
- R1: With no load in a cycle, the time value in the next cycle is the current value plus one.
- R2: A command with `cmd_op_i` = 2'b01 (set now) in the cycle `cmd_valid_i` is high makes the time value equal `cmd_time_i` in the next cycle. Counting continues upward from that value.
- R3: A command with `cmd_op_i` = 2'b10 (arm) stores `cmd_time_i` as a pending value. On the first detected pulse edge after the arm cycle, the time value becomes the pending value and counts on from there. Before that edge, counting is not disturbed.
- R4: A set-now command cancels any armed value, including one whose pulse edge is detected in the same cycle. A later pulse edge then loads nothing.
- R5: A command with `cmd_op_i` = 2'b11 (read) captures the time value of that cycle. The captured value appears on `rd_time_o`, with `rd_valid_o` high for one cycle, in the next cycle.
- R6: The time value is 64 bits wide and wraps from all-ones to zero.
- R7: `pps_i` goes through two synchronizer flops and a rising-edge detector. If `pps_i` rises between clock edges, the armed load takes effect at the third clock edge after that rise.
- R8: A request accepted with a timestamp later than the time value of its acceptance cycle makes `rel_o` high for exactly the one cycle in which the time value equals the timestamp. `late_o` stays low in that cycle.
- R9: A request accepted with a timestamp not later than the time value of its acceptance cycle makes `rel_o` and `late_o` high together for one cycle, in the cycle after acceptance.
- R10: A request is accepted when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low from acceptance until the release cycle ends. Requests offered while it is low are ignored.
- R11: Reset sets the time value to zero, cancels any armed value, drops any pending request, and leaves `req_ready_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; one tick per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pps_i | input | 1 | Asynchronous once-per-second pulse |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_op_i | input | 2 | 01 set now, 10 arm for pulse, 11 read, 00 none |
| cmd_time_i | input | 64 | Value for set-now and arm commands |
| rd_time_o | output | 64 | Captured time value |
| rd_valid_o | output | 1 | One-cycle strobe for `rd_time_o` |
| req_valid_i | input | 1 | Transmit request offered |
| req_time_i | input | 64 | Absolute release time of the request |
| req_ready_o | output | 1 | High when a request can be accepted |
| rel_o | output | 1 | Release strobe |
| late_o | output | 1 | Marks a release whose time had already passed |

## Verification
The bench aims a set-now command at the exact cycle in which the synchronized pulse edge is seen while a value is armed. A design that let the armed load win, or let it survive for the next pulse, would show the armed value in a later snapshot. It places a request at exactly the current time and one in the past. A design that compares with strict less-than would hold the first request for a full wrap, and one that drops late requests would never release it. It also offers extra requests while one is pending and resets with a request pending and a value armed. Either an extra release or a load after reset breaks the expected time sequence. A load near all-ones checks that the counter wraps modulo 2^64 rather than saturating.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int TIME_W_DEF = 64;

  typedef enum logic [1:0] {
    OP_NOP      = 2'b00,
    OP_SET_NOW  = 2'b01,
    OP_ARM_PPS  = 2'b10,
    OP_READ     = 2'b11
  } tod_op_e;
endpackage

// File: rtl/tod_pps_sync.sv
module tod_pps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pps_i,
  output logic edge_o
);
  // sh_q[STAGES] is the delayed copy used for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pps_i};
  end

  assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  p_edge_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/tod_time_reg.sv
module tod_time_reg #(
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_now_i,
  input  logic              arm_i,
  input  logic [TIME_W-1:0] val_i,
  input  logic              pps_edge_i,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] time_q, pend_q;
  logic              armed_q;
  logic              pps_load;

  assign pps_load = armed_q & pps_edge_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q  <= '0;
      pend_q  <= '0;
      armed_q <= 1'b0;
    end else if (set_now_i) begin
      // immediate load wins and drops any armed value
      time_q  <= val_i;
      armed_q <= 1'b0;
    end else begin
      if (pps_load) begin
        time_q  <= pend_q;
        armed_q <= 1'b0;
      end else begin
        time_q  <= time_q + 1'b1;
      end
      if (arm_i) begin
        pend_q  <= val_i;
        armed_q <= 1'b1;
      end
    end
  end

  assign time_o = time_q;

  p_incr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_now_i && !pps_load) |=> time_q == $past(time_q) + 1'b1);
  p_set_now_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_now_i |=> time_q == $past(val_i));
  p_pps_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pps_load && !set_now_i) |=> time_q == $past(pend_q));
  p_cancel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_now_i |=> !armed_q);
endmodule

// File: rtl/tod_tx_sched.sv
module tod_tx_sched #(
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              req_valid_i,
  input  logic [TIME_W-1:0] req_time_i,
  output logic              req_ready_o,
  output logic              rel_o,
  output logic              late_o
);
  logic [TIME_W-1:0] tgt_q;
  logic              pending_q, late_q;
  logic              accept, is_late, hit;

  assign req_ready_o = ~pending_q & ~late_q;
  assign accept      = req_valid_i & req_ready_o;
  // a timestamp equal to now cannot be met by a registered match
  assign is_late     = req_time_i <= time_i;
  assign hit         = pending_q & (time_i == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q     <= '0;
      pending_q <= 1'b0;
      late_q    <= 1'b0;
    end else begin
      late_q <= accept & is_late;
      if (hit) pending_q <= 1'b0;
      if (accept && !is_late) begin
        pending_q <= 1'b1;
        tgt_q     <= req_time_i;
      end
    end
  end

  assign rel_o  = hit | late_q;
  assign late_o = late_q;

  p_rel_exact_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_o && !late_o) |-> time_i == tgt_q);
  p_late_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_o |=> !late_o);
  p_ready_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !is_late) |=> !req_ready_o);
  p_one_owner_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pending_q && late_q));
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int TIME_W      = tod_pkg::TIME_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pps_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [TIME_W-1:0] cmd_time_i,
  output logic [TIME_W-1:0] rd_time_o,
  output logic              rd_valid_o,
  input  logic              req_valid_i,
  input  logic [TIME_W-1:0] req_time_i,
  output logic              req_ready_o,
  output logic              rel_o,
  output logic              late_o
);
  import tod_pkg::*;

  logic              pps_edge;
  logic              set_now, arm, rd_cmd;
  logic [TIME_W-1:0] time_now;
  logic [TIME_W-1:0] rd_time_q;
  logic              rd_valid_q;

  assign set_now = cmd_valid_i && (cmd_op_i == OP_SET_NOW);
  assign arm     = cmd_valid_i && (cmd_op_i == OP_ARM_PPS);
  assign rd_cmd  = cmd_valid_i && (cmd_op_i == OP_READ);

  tod_pps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pps_i  (pps_i),
    .edge_o (pps_edge)
  );

  tod_time_reg #(.TIME_W(TIME_W)) u_time (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_now_i  (set_now),
    .arm_i      (arm),
    .val_i      (cmd_time_i),
    .pps_edge_i (pps_edge),
    .time_o     (time_now)
  );

  tod_tx_sched #(.TIME_W(TIME_W)) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .time_i      (time_now),
    .req_valid_i (req_valid_i),
    .req_time_i  (req_time_i),
    .req_ready_o (req_ready_o),
    .rel_o       (rel_o),
    .late_o      (late_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_time_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_cmd;
      if (rd_cmd) rd_time_q <= time_now;
    end
  end

  assign rd_time_o  = rd_time_q;
  assign rd_valid_o = rd_valid_q;

  p_rd_snap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd |=> (rd_valid_o && rd_time_o == $past(time_now)));
  p_rd_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_cmd |=> !rd_valid_o);
endmodule

// File: tb/tod_counter_tb.sv
module tod_counter_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pps_i = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = 2'b00;
  logic [63:0] cmd_time_i = '0;
  logic [63:0] rd_time_o;
  logic        rd_valid_o;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_time_i = '0;
  logic        req_ready_o;
  logic        rel_o;
  logic        late_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [63:0] cyc = '0;
  logic [63:0] t_base = '0;
  logic [63:0] c_base = '0;

  logic [63:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [63:0] rel_t_q[$];
  logic        rel_l_q[$];
  string       rel_tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tod_counter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pps_i(pps_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_time_i(cmd_time_i),
    .rd_time_o(rd_time_o), .rd_valid_o(rd_valid_o),
    .req_valid_i(req_valid_i), .req_time_i(req_time_i),
    .req_ready_o(req_ready_o), .rel_o(rel_o), .late_o(late_o)
  );

  // expected device time in the current cycle (one tick per cycle)
  function automatic logic [63:0] cur_time();
    return t_base + (cyc - c_base);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: reads
  always @(negedge clk) begin
    if (rst_ni && rd_valid_o) begin
      if (rd_exp_q.size() == 0) check(1'b0, "R5 unexpected read strobe", 64'd1, 64'd0);
      else begin
        automatic logic [63:0] e = rd_exp_q.pop_front();
        automatic string t = rd_tag_q.pop_front();
        check(rd_time_o == e, t, rd_time_o, e);
      end
    end
  end

  // monitor: releases
  always @(negedge clk) begin
    if (rst_ni && rel_o) begin
      if (rel_t_q.size() == 0) check(1'b0, "R10 unexpected release", cur_time(), 64'd0);
      else begin
        automatic logic [63:0] et = rel_t_q.pop_front();
        automatic logic el = rel_l_q.pop_front();
        automatic string t = rel_tag_q.pop_front();
        check(cur_time() == et, {t, " time"}, cur_time(), et);
        check(late_o == el, {t, " late"}, 64'(late_o), 64'(el));
      end
    end else if (rst_ni && late_o) begin
      check(1'b0, "R9 late without release", 64'd1, 64'd0);
    end
  end

  task automatic cmd(input logic [1:0] op, input logic [63:0] v);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_time_i = v;
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_op_i = 2'b00;
  endtask

  task automatic set_now(input logic [63:0] v);
    cmd(2'b01, v);
    t_base = v; c_base = cyc;
  endtask

  task automatic rd(input string tag);
    rd_exp_q.push_back(cur_time());
    rd_tag_q.push_back(tag);
    cmd(2'b11, '0);
  endtask

  // pulse rises now; load seen at the third edge (R7)
  task automatic pulse(input bit loads, input logic [63:0] v);
    pps_i = 1'b1;
    repeat (3) @(negedge clk);
    if (loads) begin t_base = v; c_base = cyc; end
    pps_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic request(input logic [63:0] t, input bit expect_rel, input string tag);
    automatic logic [63:0] now;
    while (!req_ready_o) @(negedge clk);
    now = cur_time();
    req_valid_i = 1'b1; req_time_i = t;
    if (expect_rel) begin
      if (t <= now) begin rel_t_q.push_back(now + 1); rel_l_q.push_back(1'b1); end
      else begin rel_t_q.push_back(t); rel_l_q.push_back(1'b0); end
      rel_tag_q.push_back(tag);
    end
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    t_base = '0; c_base = cyc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_base = '0; c_base = cyc;
    // R11: reset state
    check(req_ready_o == 1'b1, "R11 ready after reset", 64'(req_ready_o), 64'd1);
    check(rel_o == 1'b0 && late_o == 1'b0, "R11 no release after reset",
          64'(rel_o), 64'd0);
    rd("R11 time starts at zero");
    repeat (5) @(negedge clk);
    rd("R1 free run");
    repeat (17) @(negedge clk);
    rd("R1 free run later");

    // R2: immediate load
    set_now(64'h0000_1234_0000_0000);
    rd("R2 set now");
    repeat (9) @(negedge clk);
    rd("R2 counts on after set");

    // R6: wrap
    set_now(64'hFFFF_FFFF_FFFF_FFFD);
    repeat (5) @(negedge clk);
    rd("R6 wrap past all-ones");

    // R3/R7: armed load on pulse, not before
    cmd(2'b10, 64'h0000_00AA_0000_0000);
    repeat (6) @(negedge clk);
    rd("R3 armed value not taken before pulse");
    pulse(1'b1, 64'h0000_00AA_0000_0000);
    rd("R3 R7 value taken on pulse edge");
    pulse(1'b0, '0);
    rd("R3 second pulse loads nothing");

    // R4: set-now in the same cycle as the detected edge
    cmd(2'b10, 64'h0000_00BB_0000_0000);
    pps_i = 1'b1;
    repeat (2) @(negedge clk);
    set_now(64'h0000_00CC_0000_0000);
    pps_i = 1'b0;
    repeat (4) @(negedge clk);
    rd("R4 set now beats armed load");
    pulse(1'b0, '0);
    rd("R4 armed value cancelled");

    // R8: future release, R10 ready low and extra offers ignored
    request(cur_time() + 30, 1'b1, "R8 on-time release");
    repeat (3) @(negedge clk);
    check(req_ready_o == 1'b0, "R10 ready low while pending", 64'(req_ready_o), 64'd0);
    req_valid_i = 1'b1; req_time_i = cur_time() + 5;
    repeat (3) @(negedge clk);
    req_valid_i = 1'b0;
    repeat (40) @(negedge clk);
    check(req_ready_o == 1'b1, "R10 ready after release", 64'(req_ready_o), 64'd1);

    // R9: past and equal-to-now timestamps
    request(cur_time() - 100, 1'b1, "R9 past timestamp");
    repeat (4) @(negedge clk);
    request(cur_time(), 1'b1, "R9 timestamp equal to now");
    repeat (4) @(negedge clk);
    request(cur_time() + 3, 1'b1, "R8 near release");
    repeat (8) @(negedge clk);

    // R11: reset drops pending request and armed value
    request(cur_time() + 60, 1'b0, "R11 dropped");
    cmd(2'b10, 64'h0000_00DD_0000_0000);
    do_reset();
    check(req_ready_o == 1'b1, "R11 ready after mid-run reset", 64'(req_ready_o), 64'd1);
    pulse(1'b0, '0);
    rd("R11 armed value cleared by reset");
    repeat (80) @(negedge clk);
    rd("R11 pending request dropped, time still counts");
    repeat (4) @(negedge clk);

    check(rd_exp_q.size() == 0, "R5 all reads returned", 64'(rd_exp_q.size()), 64'd0);
    check(rel_t_q.size() == 0, "R8 all releases seen", 64'(rel_t_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule